// File: doc/BRIEF.md
# Mixed-Latency Execution Issue Controller

This block decides whether a single offered micro-operation may enter the arithmetic units that sit behind the compute ports, and it times the completion of each accepted one. Every cycle the upstream scheduler offers at most one uop, made of an operation class and a tag. The controller answers with a ready signal. An accepted uop later comes back on a single writeback strobe with its tag unchanged. Each class has a fixed latency, and the arithmetic itself is stood in for by that delay.

Several kinds of unit are modelled. Some are fully pipelined. The floating-point multiplier issues only every other cycle. One multiplier array is shared, so a floating-point multiply also blocks an integer multiply in the cycle that follows it. The divider blocks completely until its result is done. The branch unit refuses two branches in consecutive cycles. There is one writeback strobe, so the controller refuses any uop whose completion would land in a cycle that is already claimed. A flush drops every completion that has not yet appeared.

The input follows valid/ready rules. A transfer takes place on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on the offered class and on internal state, never on `in_valid`. A refused offer is simply not taken. The producer may hold it or replace it in the next cycle. The completion side has no back-pressure: `cmp_valid` is a single-cycle strobe that the consumer must take. `flush` and `div_busy` are plain control and status pins.

Top module: `exec_issue_ctrl`

## Requirements
- R1: The `in_class` encoding and latency L are: 0 simple ALU L=1, 1 FP add/sub L=3, 2 integer multiply L=4, 3 packed-integer multiply L=3, 4 FP multiply L=5, 5 divide/sqrt/transcendental L=39, 6 branch L=1, 7 reserved. A uop accepted in cycle c produces `cmp_valid`=1 with `cmp_tag` equal to its tag in cycle c+L, and in no other cycle.
- R2: Classes 0, 1, 2 and 3 each accept a new uop in every cycle, subject only to R4, R7 and R8.
- R3: An FP multiply is refused in the cycle right after an FP multiply was accepted.
- R4: An integer multiply is refused in the cycle right after an FP multiply was accepted. A packed-integer multiply in that cycle is not affected.
- R5: After a divide is accepted in cycle c, `div_busy` is high in cycles c+1 through c+38 and low in cycle c+39. A divide is refused whenever `div_busy` is high.
- R6: A branch is refused in the cycle right after a branch was accepted.
- R7: A uop whose completion cycle (current cycle plus its L) is already held by an earlier accepted uop is refused, so `cmp_valid` never carries two results at once.
- R8: While `flush` is high, `in_ready` is low. Every completion due after the flush cycle is dropped. The divider, the FP-multiply gap and the branch gap are all free from the next cycle on.
- R9: Class 7 is never accepted.
- R10: After reset `cmp_valid` and `div_busy` are low and every unit is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Cancel all pending completions and free all units |
| in_valid | input | 1 | An offered uop is present |
| in_ready | output | 1 | The offered class can be accepted this cycle |
| in_class | input | 3 | Operation class, encoded as in R1 |
| in_tag | input | TAG_W | Tag of the offered uop |
| cmp_valid | output | 1 | Completion strobe |
| cmp_tag | output | TAG_W | Tag of the completing uop |
| div_busy | output | 1 | Divider occupied |

## Verification
The hardest state to reach is one where two constraints overlap. One case is a writeback clash with a result that was issued tens of cycles earlier by the divider. Another is an FP-multiply gap that coincides with a claimed completion slot. A third is a flush that lands while a divide and several short operations are still in flight. Directed sequences place an ALU uop exactly one cycle before a divide completes. They also follow an integer multiply with an FP add so that both aim at the same cycle, and they flush with mixed work outstanding. A long random phase then combines every class with occasional flushes, while a behavioural model predicts the ready signal and the completion stream for every cycle.

// File: rtl/eic_pkg.sv
package eic_pkg;

  typedef enum logic [2:0] {
    CLS_ALU  = 3'd0,
    CLS_FADD = 3'd1,
    CLS_IMUL = 3'd2,
    CLS_MMUL = 3'd3,
    CLS_FMUL = 3'd4,
    CLS_DIV  = 3'd5,
    CLS_BR   = 3'd6,
    CLS_RSVD = 3'd7
  } uop_cls_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eic_lat_map.sv
module eic_lat_map
  import eic_pkg::*;
#(
  parameter int LAT_ALU  = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_IMUL = 4,
  parameter int LAT_MMUL = 3,
  parameter int LAT_FMUL = 5,
  parameter int LAT_DIV  = 39,
  parameter int LAT_BR   = 1,
  parameter int MAX_LAT  = 39,
  parameter int LAT_W    = 6
) (
  input  logic [2:0]       cls,
  output logic [LAT_W-1:0] lat
);

  uop_cls_e cls_e;
  assign cls_e = uop_cls_e'(cls);

  always_comb begin
    unique case (cls_e)
      CLS_ALU:  lat = LAT_W'(LAT_ALU);
      CLS_FADD: lat = LAT_W'(LAT_FADD);
      CLS_IMUL: lat = LAT_W'(LAT_IMUL);
      CLS_MMUL: lat = LAT_W'(LAT_MMUL);
      CLS_FMUL: lat = LAT_W'(LAT_FMUL);
      CLS_DIV:  lat = LAT_W'(LAT_DIV);
      CLS_BR:   lat = LAT_W'(LAT_BR);
      default:  lat = LAT_W'(MAX_LAT); // reserved: in-range index, never issued
    endcase
  end

endmodule

// File: rtl/eic_timeline.sv
// Completion timeline: slot j holds the result due j-1 cycles from now.
module eic_timeline #(
  parameter int TAG_W = 6,
  parameter int DEPTH = 39,
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [LAT_W-1:0] wr_lat,
  input  logic [TAG_W-1:0] wr_tag,
  output logic [DEPTH+1:1] occ,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag
);

  logic [DEPTH+1:1] vq;
  logic [TAG_W-1:0] tq [DEPTH+1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq <= '0;
      for (int j = 1; j <= DEPTH + 1; j++) tq[j] <= '0;
    end else begin
      for (int j = 1; j <= DEPTH; j++) begin
        if (flush) begin
          vq[j] <= 1'b0;
        end else if (wr_en && (wr_lat == LAT_W'(j))) begin
          vq[j] <= 1'b1;
          tq[j] <= wr_tag;
        end else begin
          vq[j] <= vq[j+1];
          tq[j] <= tq[j+1];
        end
      end
    end
  end

  assign occ      = vq;
  assign rd_valid = vq[1];
  assign rd_tag   = tq[1];

endmodule

// File: rtl/eic_unit_gate.sv
// Per-unit issue rules: FP-multiply gap shared with integer multiply,
// branch gap, blocking divider.
module eic_unit_gate
  import eic_pkg::*;
#(
  parameter int LAT_DIV = 39,
  parameter int CNT_W   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       valid,
  input  logic [2:0] cls,
  input  logic       wb_clash,
  output logic       ready,
  output logic       div_busy
);

  uop_cls_e         cls_e;
  logic             fmul_prev;
  logic             br_prev;
  logic [CNT_W-1:0] div_cnt;
  logic             unit_ok;
  logic             fire;

  assign cls_e = uop_cls_e'(cls);

  always_comb begin
    unique case (cls_e)
      CLS_FMUL, CLS_IMUL: unit_ok = !fmul_prev;
      CLS_BR:             unit_ok = !br_prev;
      CLS_DIV:            unit_ok = (div_cnt == '0);
      CLS_RSVD:           unit_ok = 1'b0;
      default:            unit_ok = 1'b1;
    endcase
  end

  assign ready    = unit_ok && !wb_clash && !flush;
  assign fire     = valid && ready;
  assign div_busy = (div_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmul_prev <= 1'b0;
      br_prev   <= 1'b0;
      div_cnt   <= '0;
    end else if (flush) begin
      fmul_prev <= 1'b0;
      br_prev   <= 1'b0;
      div_cnt   <= '0;
    end else begin
      fmul_prev <= fire && (cls_e == CLS_FMUL);
      br_prev   <= fire && (cls_e == CLS_BR);
      if (fire && (cls_e == CLS_DIV))
        div_cnt <= CNT_W'(LAT_DIV - 1);
      else if (div_cnt != '0)
        div_cnt <= div_cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/exec_issue_ctrl.sv
module exec_issue_ctrl
  import eic_pkg::*;
#(
  parameter int TAG_W    = 6,
  parameter int LAT_ALU  = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_IMUL = 4,
  parameter int LAT_MMUL = 3,
  parameter int LAT_FMUL = 5,
  parameter int LAT_DIV  = 39,
  parameter int LAT_BR   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_class,
  input  logic [TAG_W-1:0] in_tag,
  output logic             cmp_valid,
  output logic [TAG_W-1:0] cmp_tag,
  output logic             div_busy
);

  localparam int MAX_LAT = imax(imax(imax(LAT_ALU, LAT_FADD), imax(LAT_IMUL, LAT_MMUL)),
                                imax(imax(LAT_FMUL, LAT_DIV), LAT_BR));
  localparam int LAT_W   = $clog2(MAX_LAT + 2);
  localparam int CNT_W   = $clog2(LAT_DIV + 1);

  logic [LAT_W-1:0]   lat;
  logic [MAX_LAT+1:1] occ;
  logic               wb_clash;
  logic               fire;

  eic_lat_map #(
    .LAT_ALU(LAT_ALU), .LAT_FADD(LAT_FADD), .LAT_IMUL(LAT_IMUL),
    .LAT_MMUL(LAT_MMUL), .LAT_FMUL(LAT_FMUL), .LAT_DIV(LAT_DIV),
    .LAT_BR(LAT_BR), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)
  ) u_lat (
    .cls (in_class),
    .lat (lat)
  );

  // A new result lands in slot lat+1 before this edge's shift.
  assign wb_clash = occ[lat + LAT_W'(1)];

  eic_unit_gate #(
    .LAT_DIV(LAT_DIV), .CNT_W(CNT_W)
  ) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .valid    (in_valid),
    .cls      (in_class),
    .wb_clash (wb_clash),
    .ready    (in_ready),
    .div_busy (div_busy)
  );

  assign fire = in_valid && in_ready;

  eic_timeline #(
    .TAG_W(TAG_W), .DEPTH(MAX_LAT), .LAT_W(LAT_W)
  ) u_tl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (fire),
    .wr_lat   (lat),
    .wr_tag   (in_tag),
    .occ      (occ),
    .rd_valid (cmp_valid),
    .rd_tag   (cmp_tag)
  );

endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int TAG_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_class,
  input logic [TAG_W-1:0] in_tag,
  input logic             cmp_valid,
  input logic [TAG_W-1:0] cmp_tag,
  input logic             div_busy
);

  logic take;
  assign take = in_valid && in_ready;

  a_r1_alu_next: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_class == 3'd0) |=> (cmp_valid && cmp_tag == $past(in_tag)))
    else $error("R1 ALU completion not in following cycle");

  a_r3_fmul_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_class == 3'd4) |=> !(take && in_class == 3'd4))
    else $error("R3 FP multiply issued back to back");

  a_r4_imul_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_class == 3'd4) |=> !(take && in_class == 3'd2))
    else $error("R4 integer multiply in FP multiply gap");

  a_r5_div_block: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_class == 3'd5) |-> !div_busy)
    else $error("R5 divide issued while busy");

  a_r5_div_set: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_class == 3'd5) |=> div_busy)
    else $error("R5 busy not raised after divide");

  a_r6_branch_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_class == 3'd6) |=> !(take && in_class == 3'd6))
    else $error("R6 branches back to back");

  a_r8_flush_block: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready)
    else $error("R8 ready during flush");

  a_r8_flush_drop: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !cmp_valid)
    else $error("R8 completion after flush");

  a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_class == 3'd7) |-> !in_ready)
    else $error("R9 reserved class ready");

endmodule

bind exec_issue_ctrl eic_checker #(.TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_class  (in_class),
  .in_tag    (in_tag),
  .cmp_valid (cmp_valid),
  .cmp_tag   (cmp_tag),
  .div_busy  (div_busy)
);

// File: tb/exec_issue_ctrl_tb.sv
`timescale 1ns/1ps
module exec_issue_ctrl_tb;

  localparam int TAG_W = 6;

  logic             clk, rst_n, flush, in_valid, in_ready, cmp_valid, div_busy;
  logic [2:0]       in_class;
  logic [TAG_W-1:0] in_tag, cmp_tag;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference state
  int cyc = 0, div_free = 0, last_fmul = -10, last_br = -10;
  int due_q[$];
  int tag_q[$];

  exec_issue_ctrl #(.TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_class(in_class), .in_tag(in_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .div_busy(div_busy)
  );

  initial begin
    clk = 0;
    forever #2.5 clk = ~clk;
  end

  function automatic int lat_of(int c);
    case (c)
      0: return 1;  1: return 3;  2: return 4;  3: return 3;
      4: return 5;  5: return 39; 6: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic step(bit v, int c, int tg, bit fl);
    int ev, et, L;
    bit er;
    string rq;
    @(negedge clk);
    ev = 0; et = 0;
    foreach (due_q[i]) if (due_q[i] == cyc) begin ev = 1; et = tag_q[i]; end
    check(cmp_valid == ev, "R1", "cmp_valid", cmp_valid, ev);
    if (ev && cmp_valid) check(cmp_tag == et, "R1", "cmp_tag", cmp_tag, et);
    check(div_busy == (cyc < div_free), "R5", "div_busy", div_busy, cyc < div_free);
    for (int i = due_q.size() - 1; i >= 0; i--)
      if (due_q[i] <= cyc) begin due_q.delete(i); tag_q.delete(i); end
    in_valid = v; in_class = c[2:0]; in_tag = tg[TAG_W-1:0]; flush = fl;
    #1;
    L = lat_of(c); er = 1; rq = "R2";
    if (fl) begin er = 0; rq = "R8"; end
    else if (c == 7) begin er = 0; rq = "R9"; end
    else if (c == 4 && last_fmul == cyc - 1) begin er = 0; rq = "R3"; end
    else if (c == 2 && last_fmul == cyc - 1) begin er = 0; rq = "R4"; end
    else if (c == 6 && last_br == cyc - 1) begin er = 0; rq = "R6"; end
    else if (c == 5 && cyc < div_free) begin er = 0; rq = "R5"; end
    else foreach (due_q[i]) if (due_q[i] == cyc + L) begin er = 0; rq = "R7"; end
    check(in_ready == er, rq, "in_ready", in_ready, er);
    if (fl) begin
      due_q.delete(); tag_q.delete();
      div_free = 0; last_fmul = -10; last_br = -10;
    end else if (v && er) begin
      due_q.push_back(cyc + L); tag_q.push_back(tg % 64);
      if (c == 4) last_fmul = cyc;
      if (c == 6) last_br = cyc;
      if (c == 5) div_free = cyc + L;
    end
    cyc++;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; flush = 0; in_valid = 0; in_class = 0; in_tag = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(cmp_valid == 0, "R10", "cmp_valid after reset", cmp_valid, 0);
    check(div_busy == 0, "R10", "div_busy after reset", div_busy, 0);
    rst_n = 1;
    // R1: each class alone
    for (int c = 0; c < 7; c++) begin step(1, c, 10 + c, 0); idle(42); end
    // R2: back-to-back pipelined classes
    for (int k = 0; k < 4; k++) step(1, 1, 20 + k, 0);
    for (int k = 0; k < 4; k++) step(1, 2, 24 + k, 0);
    for (int k = 0; k < 4; k++) step(1, 3, 28 + k, 0);
    idle(8);
    // R3: FP multiply gap, producer keeps offering
    for (int k = 0; k < 4; k++) step(1, 4, 32 + k, 0);
    idle(8);
    // R4: integer multiply shadowed, packed multiply not
    step(1, 4, 36, 0); step(1, 2, 37, 0); step(1, 2, 37, 0); idle(8);
    step(1, 4, 38, 0); step(1, 3, 39, 0); idle(8);
    // R6: branch gap
    for (int k = 0; k < 4; k++) step(1, 6, 40 + k, 0);
    idle(4);
    // R5: divide then repeated divide offers; R7: ALU aimed at divide completion
    step(1, 5, 44, 0);
    for (int k = 0; k < 37; k++) step(1, 5, 45, 0);
    step(1, 0, 46, 0);
    step(1, 5, 47, 0);
    idle(42);
    // R7: integer multiply then FP add targeting same cycle
    step(1, 2, 48, 0); step(1, 1, 49, 0); step(1, 1, 49, 0); idle(8);
    // R8: flush with work in flight
    step(1, 5, 50, 0); step(1, 1, 51, 0); step(1, 2, 52, 0); step(1, 4, 53, 0);
    step(1, 0, 54, 1);
    step(1, 4, 55, 0); step(1, 5, 56, 0); idle(4);
    step(0, 0, 0, 1); idle(4);
    // R9: reserved class
    step(1, 7, 57, 0); step(1, 7, 58, 0); idle(2);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      int c;
      c = ($urandom_range(0, 9) < 2) ? 5 : $urandom_range(0, 7);
      step($urandom_range(0, 3) != 0, c, $urandom_range(0, 63), $urandom_range(0, 149) == 0);
    end
    idle(45);
    done = 1;
    summary();
    $finish;
  end

endmodule